// File: doc/BRIEF.md
# Buffered JTAG Shift Master

This block drives a JTAG port from words that a host has queued. Each 32-bit word written into the transmit queue holds sixteen bits for the test-mode-select line and sixteen bits for the test-data-input line. The engine replays both streams together, one bit per test clock period. While it shifts, it samples the test-data-output line and packs sixteen samples into a word for the receive queue, which the host drains at its own pace.

The host may load several words before it issues a start pulse. Nothing moves on the port until that pulse. The test clock is derived from the system clock by a programmable divider. When the transmit queue runs dry, the engine finishes the current word, parks the test clock low and waits for the next start. When the receive queue is full as a word completes, that captured word is thrown away. The block does not track TAP state: it only plays back the sequence it is given.

Top module: `jtag_shift_master`

## Requirements
- R1: A transmit word carries the TDI stream in bits 15:0 and the TMS stream in bits 31:16. Both streams go out least-significant bit first, one bit per TCK period, over the same 16 periods.
- R2: TDO is sampled at each rising TCK edge. The 16 samples of a word fill the receive word from bit 0 upward, and that word is pushed into the receive queue after the word's last falling TCK edge.
- R3: Each queue holds 8 words. `tx_full` is high after 8 unread writes and `rx_full` is high after 8 unread captured words. A queue is never flagged full and empty at once.
- R4: A write while `tx_full` is high is discarded. The queued contents and the number of words shifted are unchanged by it.
- R5: Writing words without a start pulse leaves `busy` low and TCK low.
- R6: A start pulse while the transmit queue is empty has no effect: `busy` stays low and TCK does not toggle.
- R7: If the transmit queue is empty when a word finishes, `busy` falls at that word's last falling TCK edge and TCK stays low. A later start resumes shifting.
- R8: A captured word that completes while `rx_full` is high is dropped, and the words already in the receive queue are kept in order.
- R9: Each TCK half period lasts `div_val`+1 system cycles, so one word takes 32×(`div_val`+1) cycles; with `div_val`=9, `busy` stays high for 320 cycles for a single word.
- R10: When a word finishes and the transmit queue holds another word, that word starts with no extra TCK low time: two queued words keep `busy` high for 64×(`div_val`+1) cycles and give 32 rising TCK edges.
- R11: TMS and TDI change only at the start command or at a falling TCK edge, never while TCK is high. TCK is low whenever `busy` is low.
- R12: After reset, TCK, TMS, TDI and `busy` are low, both queues are empty, and neither is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Push `tx_wr_data` into the transmit queue |
| tx_wr_data | input | 32 | TMS stream in [31:16], TDI stream in [15:0] |
| rx_rd_en | input | 1 | Pop the head of the receive queue |
| rx_rd_data | output | 16 | Head of the receive queue (show-ahead) |
| start | input | 1 | Begin shifting when idle and data is queued |
| div_val | input | 8 | TCK half period minus one, in system cycles |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target, synchronous to `clk` |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Engine running, from start until it parks |

## Verification
The properties take for granted that `div_val` is held constant while `busy` is high, and that `tdo` is driven synchronously to `clk`. Otherwise the divider compare and the TDO capture have no defined meaning. The bench changes `div_val` only between runs. It also loops TDO back as the XOR of the block's own TMS and TDI outputs, which come from registers, so the sampled value is stable at every capture edge and the expected receive word is known from the transmit word alone.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  localparam int unsigned LANE_W = 16;

  typedef struct packed {
    logic [LANE_W-1:0] mode_bits;
    logic [LANE_W-1:0] data_bits;
  } jsm_word_t;
endpackage

// File: rtl/jsm_fifo.sv
module jsm_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FILL_MAX = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [AW:0]      fill_q, fill_d;
  logic             push_ok, pop_ok;

  assign full    = (fill_q == FILL_MAX);
  assign empty   = (fill_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = store[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push_ok ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      store[wr_ptr_q] <= push_data;
    end
  end
endmodule

// File: rtl/jsm_tck_div.sv
module jsm_tck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div_val);

  always_comb begin
    if (restart || !run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/jsm_shift_engine.sv
module jsm_shift_engine
  import jsm_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tx_empty,
  input  jsm_word_t         tx_head,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [LANE_W-1:0] rx_word,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy
);
  localparam int unsigned BW = $clog2(LANE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(LANE_W - 1);

  logic              busy_q, busy_d;
  logic              tck_q, tck_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [LANE_W-1:0] mode_sh_q, mode_sh_d;
  logic [LANE_W-1:0] data_sh_q, data_sh_d;
  logic [LANE_W-1:0] cap_q, cap_d;
  logic              tick, launch;

  jsm_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (launch),
    .div_val (div_val),
    .tick    (tick)
  );

  assign launch  = start && !busy_q && !tx_empty;
  assign tck     = tck_q;
  assign tms     = mode_sh_q[0];
  assign tdi     = data_sh_q[0];
  assign busy    = busy_q;
  assign rx_word = cap_q;

  always_comb begin
    busy_d    = busy_q;
    tck_d     = tck_q;
    bit_d     = bit_q;
    mode_sh_d = mode_sh_q;
    data_sh_d = data_sh_q;
    cap_d     = cap_q;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    if (launch) begin
      busy_d    = 1'b1;
      tck_d     = 1'b0;
      bit_d     = '0;
      mode_sh_d = tx_head.mode_bits;
      data_sh_d = tx_head.data_bits;
      tx_pop    = 1'b1;
    end else if (busy_q && tick) begin
      if (!tck_q) begin
        tck_d        = 1'b1;
        cap_d[bit_q] = tdo;
      end else begin
        tck_d = 1'b0;
        if (bit_q == LAST_BIT) begin
          rx_push = 1'b1;
          if (!tx_empty) begin
            bit_d     = '0;
            mode_sh_d = tx_head.mode_bits;
            data_sh_d = tx_head.data_bits;
            tx_pop    = 1'b1;
          end else begin
            busy_d = 1'b0;
          end
        end else begin
          bit_d     = bit_q + 1'b1;
          mode_sh_d = {1'b0, mode_sh_q[LANE_W-1:1]};
          data_sh_d = {1'b0, data_sh_q[LANE_W-1:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tck_q     <= 1'b0;
      bit_q     <= '0;
      mode_sh_q <= '0;
      data_sh_q <= '0;
      cap_q     <= '0;
    end else begin
      busy_q    <= busy_d;
      tck_q     <= tck_d;
      bit_q     <= bit_d;
      mode_sh_q <= mode_sh_d;
      data_sh_q <= data_sh_d;
      cap_q     <= cap_d;
    end
  end
endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
  import jsm_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_en,
  input  logic [2*LANE_W-1:0] tx_wr_data,
  input  logic              rx_rd_en,
  output logic [LANE_W-1:0] rx_rd_data,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_val,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              busy
);
  localparam int unsigned TXW = $bits(jsm_word_t);

  logic [TXW-1:0]    tx_head_raw;
  jsm_word_t         tx_head;
  logic              tx_pop;
  logic              rx_push;
  logic [LANE_W-1:0] rx_word;

  assign tx_head = jsm_word_t'(tx_head_raw);

  jsm_fifo #(.WIDTH(TXW), .DEPTH(DEPTH)) u_tx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_wr_en),
    .push_data (tx_wr_data),
    .pop       (tx_pop),
    .head      (tx_head_raw),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  jsm_fifo #(.WIDTH(LANE_W), .DEPTH(DEPTH)) u_rx_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_word),
    .pop       (rx_rd_en),
    .head      (rx_rd_data),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  jsm_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .div_val  (div_val),
    .tx_empty (tx_empty),
    .tx_head  (tx_head),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .rx_word  (rx_word),
    .tdo      (tdo),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .busy     (busy)
  );
endmodule

// File: rtl/jsm_checker.sv
module jsm_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_wr_en,
  input logic rx_rd_en,
  input logic start,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic tx_full,
  input logic tx_empty,
  input logic rx_full,
  input logic rx_empty,
  input logic busy
);
  AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck); // R11

  AST_LANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(tck)) |-> ($stable(tms) && $stable(tdi))); // R11

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr_en && !busy && !start) |=> tx_full); // R4

  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(tx_empty))); // R6

  AST_PARK_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tx_empty) && !tck)); // R7

  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rd_en) |=> rx_full); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R3
endmodule

bind jtag_shift_master jsm_checker u_jsm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_wr_en (tx_wr_en),
  .rx_rd_en (rx_rd_en),
  .start    (start),
  .tck      (tck),
  .tms      (tms),
  .tdi      (tdi),
  .tx_full  (tx_full),
  .tx_empty (tx_empty),
  .rx_full  (rx_full),
  .rx_empty (rx_empty),
  .busy     (busy)
);

// File: tb/jtag_shift_master_tb_top.sv
`timescale 1ns/1ps
module jtag_shift_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_wr_en = 1'b0;
  logic [31:0] tx_wr_data = '0;
  logic        rx_rd_en = 1'b0;
  logic [15:0] rx_rd_data;
  logic        start = 1'b0;
  logic [7:0]  div_val = 8'd1;
  logic        tck, tms, tdi, tdo;
  logic        tx_full, tx_empty, rx_full, rx_empty, busy;

  int n_chk = 0;
  int n_fail = 0;

  // Captured lanes at each rising TCK edge
  logic [511:0] mon_tms;
  logic [511:0] mon_tdi;
  int mon_n = 0;

  always #2.5 clk = ~clk;

  assign tdo = tms ^ tdi;

  jtag_shift_master dut_i (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .start(start), .div_val(div_val),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .busy(busy)
  );

  always @(posedge tck) begin
    if (mon_n < 512) begin
      mon_tms[mon_n] = tms;
      mon_tdi[mon_n] = tdi;
    end
    mon_n = mon_n + 1;
  end

  // {tx word, expected rx word = tms ^ tdi}
  localparam logic [47:0] VEC [4] = '{
    48'hA5A5_0F0F_AAAA,
    48'h0000_FFFF_FFFF,
    48'h1234_1234_0000,
    48'hFFFF_8001_7FFE
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    tx_wr_en = 1'b1;
    tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_count(output int cyc);
    cyc = 0;
    while (busy && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic pop_word(output logic [15:0] w);
    w = rx_rd_data;
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  function automatic logic [15:0] pick(input logic [511:0] v, input int base);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[b] = v[base + b];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] got;
    logic [15:0] exp_rx [8];
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!tck && !tms && !tdi && !busy, "R12", {tck, tms, tdi, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_empty && rx_empty && !tx_full && !rx_full, "R12",
          {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);

    // R6 start with nothing queued
    pulse_start();
    repeat (6) @(negedge clk);
    check(!busy && !tck && mon_n == 0, "R6", {busy, tck, 8'(mon_n)}, 0);

    // Vector table walk, div_val = 1
    foreach (VEC[i]) push_word(VEC[i][47:16]);
    repeat (10) @(negedge clk);
    check(!busy && !tck && !tx_empty, "R5", {busy, tck, tx_empty}, 0);
    mon_n = 0;
    pulse_start();
    run_count(cyc);
    check(cyc == 4 * 32 * 2, "R10", cyc, 256);
    check(mon_n == 64, "R1", mon_n, 64);
    foreach (VEC[i]) begin
      check(pick(mon_tdi, i * 16) == VEC[i][31:16], "R1", pick(mon_tdi, i * 16), VEC[i][31:16]);
      check(pick(mon_tms, i * 16) == VEC[i][47:32], "R1", pick(mon_tms, i * 16), VEC[i][47:32]);
      pop_word(got);
      check(got == VEC[i][15:0], "R2", got, VEC[i][15:0]);
    end
    check(rx_empty, "R2", rx_empty, 1);

    // Fill, overfill and overrun
    for (int i = 0; i < 8; i++) begin
      push_word({16'h00F0 + 16'(i), 16'h1000 + 16'(i)});
      exp_rx[i] = (16'h00F0 + 16'(i)) ^ (16'h1000 + 16'(i));
    end
    check(tx_full, "R3", tx_full, 1);
    push_word(32'hDEAD_BEEF);
    check(tx_full && !busy, "R4", {tx_full, busy}, 2'b10);
    mon_n = 0;
    pulse_start();
    run_count(cyc);
    check(mon_n == 128, "R4", mon_n, 128);
    check(rx_full && tx_empty, "R3", {rx_full, tx_empty}, 2'b11);
    push_word(32'hFFFF_0000);
    pulse_start();
    run_count(cyc);
    check(!busy && rx_full, "R8", {busy, rx_full}, 2'b01);
    for (int i = 0; i < 8; i++) begin
      pop_word(got);
      check(got == exp_rx[i], "R8", got, exp_rx[i]);
    end
    check(rx_empty, "R8", rx_empty, 1);

    // Timing at div_val = 9, single word, then park
    div_val = 8'd9;
    push_word(32'h0F0F_3C3C);
    mon_n = 0;
    pulse_start();
    run_count(cyc);
    check(cyc == 320, "R9", cyc, 320);
    check(mon_n == 16, "R9", mon_n, 16);
    repeat (25) @(negedge clk);
    check(!busy && !tck && mon_n == 16, "R7", {busy, tck, 8'(mon_n)}, 8'd16);
    check(!tck, "R11", tck, 0);

    // Restart after park, two words back to back at div_val = 2
    div_val = 8'd2;
    push_word(32'h8888_1111);
    push_word(32'h7777_EEEE);
    mon_n = 0;
    pulse_start();
    run_count(cyc);
    check(cyc == 64 * 3, "R10", cyc, 192);
    check(mon_n == 32, "R7", mon_n, 32);
    pop_word(got);
    check(got == (16'h0F0F ^ 16'h3C3C), "R2", got, 16'h0F0F ^ 16'h3C3C);
    pop_word(got);
    check(got == (16'h8888 ^ 16'h1111), "R10", got, 16'h9999);
    pop_word(got);
    check(got == (16'h7777 ^ 16'hEEEE), "R10", got, 16'h9999);
    check(rx_empty && !tck, "R11", {rx_empty, tck}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule